// File: doc/BRIEF.md
# Partitionable Packed SIMD Adder

This unit takes two 64-bit register operands and treats them as packed vectors. It adds or subtracts them lane by lane, with a lane size of 8, 16 or 32 bits picked at run time. It can also form the bitwise AND or OR of the full words. A single byte-segmented carry chain serves every lane size. The chain is cut at the boundaries of the selected lanes, so no carry or borrow crosses from one lane into the next.

Each lane detects its own overflow. The signedness input decides whether that means an unsigned carry or borrow, or a signed overflow. When saturation is enabled, a lane that overflows is clamped to its bound instead of wrapping. The unit reads only its two operand inputs and has no memory port.

The result and a per-lane overflow flag vector are registered. Both appear one clock after the inputs are presented. The block has no state machine: the only state is the output register. It holds zero in reset and otherwise reloads on every clock.

Top module: `simd_packed_alu`

## Requirements
- R1: While `rst_n` is low, `result` and `lane_ovf` are zero.
- R2: `result` and `lane_ovf` reflect the inputs sampled at the previous rising clock edge. They do not change between edges.
- R3: With `op`=2'b00 (add) or 2'b01 (subtract) and `sat_en`=0, each lane's result is the lane sum or difference modulo 2^lane width. No carry or borrow crosses a lane boundary.
- R4: With `op`=2'b10 (AND) or 2'b11 (OR), `result` is the full 64-bit bitwise AND or OR of the operands. `lane_ovf` is zero, and `lane_sz`, `sat_en` and `is_signed` have no effect.
- R5: With `sat_en`=1 and `is_signed`=0, a lane whose unsigned add carries out is set to all ones. A lane whose unsigned subtract borrows is set to zero.
- R6: With `sat_en`=1 and `is_signed`=1, a lane whose signed result overflows is set to the lane's most positive value if operand A's lane is non-negative, and to its most negative value otherwise.
- R7: For add or subtract, `lane_ovf` bit k is 1 exactly when lane k (lane 0 in the least significant bits) overflows, in the sense set by `is_signed`, whether or not `sat_en` is set. Bits at or above the lane count are zero.
- R8: `lane_sz` encodes 2'b00 = eight 8-bit lanes, 2'b01 = four 16-bit lanes and 2'b10 = two 32-bit lanes. The reserved code 2'b11 behaves as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 64 | Packed operand A |
| opb | input | 64 | Packed operand B |
| op | input | 2 | 00 add, 01 subtract (A-B), 10 AND, 11 OR |
| lane_sz | input | 2 | Lane size code |
| sat_en | input | 1 | 1 = saturating, 0 = wraparound |
| is_signed | input | 1 | 1 = signed lanes, 0 = unsigned |
| result | output | 64 | Registered packed result |
| lane_ovf | output | 8 | Registered per-lane overflow flags |

## Verification
A chain cut in the wrong place shows up as a carry or borrow leaking into the neighbouring lane. The first such error is visible in the result of the very next clock, provided the lower lane carries at that boundary. For that reason the stimulus mixes all-ones and all-zeros bytes with random data.

A wrong overflow decision, or a clamp value with the wrong sign, appears as a wrong flag bit or a wrong lane value one cycle after the operands are presented. The flag vector exposes the overflow decision even in wraparound mode, so an error there is not hidden when the wrapped value happens to look correct.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int DATA_W = 64;
    localparam int SEG_W  = 8;
    localparam int NSEG   = DATA_W / SEG_W;
    localparam int NSIZES = 3;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } simd_op_e;

    typedef enum logic [1:0] {
        SZ_8   = 2'b00,
        SZ_16  = 2'b01,
        SZ_32  = 2'b10,
        SZ_RSV = 2'b11
    } lane_sz_e;
endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
    parameter int NSEG  = 8,
    parameter int SEG_W = 8,
    localparam int W    = NSEG * SEG_W
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            sub,
    input  logic [NSEG-1:0] cut,
    output logic [W-1:0]    sum,
    output logic [NSEG-1:0] cout
);
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        logic [SEG_W-1:0] bx;
        logic             cin;
        assign bx = b[i*SEG_W +: SEG_W] ^ {SEG_W{sub}};
        if (i == 0) begin : g_first
            assign cin = sub;
        end else begin : g_rest
            assign cin = cut[i] ? sub : cout[i-1];
        end
        assign {cout[i], sum[i*SEG_W +: SEG_W]} =
            {1'b0, a[i*SEG_W +: SEG_W]} + {1'b0, bx} + {{SEG_W{1'b0}}, cin};
    end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat #(
    parameter int W = 8
) (
    input  logic         a_msb,
    input  logic         bx_msb,
    input  logic [W-1:0] sum,
    input  logic         cout,
    input  logic         sub,
    input  logic         sat_en,
    input  logic         is_signed,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic         u_ovf;
    logic         s_ovf;
    logic [W-1:0] clamp;

    always_comb begin
        u_ovf = sub ? ~cout : cout;
        s_ovf = (a_msb == bx_msb) && (sum[W-1] != a_msb);
        ovf   = is_signed ? s_ovf : u_ovf;
        if (is_signed)
            clamp = a_msb ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else
            clamp = sub ? {W{1'b0}} : {W{1'b1}};
        res = (sat_en && ovf) ? clamp : sum;
    end
endmodule

// File: rtl/simd_packed_alu.sv
module simd_packed_alu
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        op,
    input  logic [1:0]        lane_sz,
    input  logic              sat_en,
    input  logic              is_signed,
    output logic [DATA_W-1:0] result,
    output logic [NSEG-1:0]   lane_ovf
);
    simd_op_e  op_e;
    lane_sz_e  sz_e;
    logic [1:0] sz_idx;
    logic       sub;
    logic [NSEG-1:0] cut;
    logic [DATA_W-1:0] sum;
    logic [NSEG-1:0]   cout;
    logic [NSIZES-1:0][DATA_W-1:0] sz_res;
    logic [NSIZES-1:0][NSEG-1:0]   sz_ovf;
    logic [DATA_W-1:0] res_d;
    logic [NSEG-1:0]   ovf_d;

    assign op_e = simd_op_e'(op);
    assign sz_e = lane_sz_e'(lane_sz);
    assign sub  = (op_e == OP_SUB);

    always_comb begin
        unique case (sz_e)
            SZ_16:   sz_idx = 2'd1;
            SZ_32:   sz_idx = 2'd2;
            default: sz_idx = 2'd0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NSEG; i++)
            cut[i] = ((i % (1 << sz_idx)) == 0);
    end

    simd_seg_adder #(.NSEG(NSEG), .SEG_W(SEG_W)) u_chain (
        .a(opa), .b(opb), .sub(sub), .cut(cut), .sum(sum), .cout(cout)
    );

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        localparam int LW = SEG_W << s;
        localparam int NL = DATA_W / LW;
        localparam int SPL = LW / SEG_W;
        for (genvar k = 0; k < NSEG; k++) begin : g_lane
            if (k < NL) begin : g_live
                simd_lane_sat #(.W(LW)) u_sat (
                    .a_msb    (opa[(k+1)*LW-1]),
                    .bx_msb   (opb[(k+1)*LW-1] ^ sub),
                    .sum      (sum[k*LW +: LW]),
                    .cout     (cout[(k+1)*SPL-1]),
                    .sub      (sub),
                    .sat_en   (sat_en),
                    .is_signed(is_signed),
                    .res      (sz_res[s][k*LW +: LW]),
                    .ovf      (sz_ovf[s][k])
                );
            end else begin : g_pad
                assign sz_ovf[s][k] = 1'b0;
            end
        end
    end

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                res_d = sz_res[sz_idx];
                ovf_d = sz_ovf[sz_idx];
            end
            OP_AND: begin
                res_d = opa & opb;
                ovf_d = '0;
            end
            default: begin
                res_d = opa | opb;
                ovf_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            lane_ovf <= '0;
        end else begin
            result   <= res_d;
            lane_ovf <= ovf_d;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && lane_ovf == '0));

    assert_logic_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 2'b10) |-> result == $past(opa & opb));

    assert_logic_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 2'b11) |-> result == $past(opa | opb));

    assert_logic_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op[1])) |-> lane_ovf == '0);

    assert_unused_flags_w_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lane_sz) == 2'b10) |-> lane_ovf[NSEG-1:2] == '0);

    assert_unused_flags_h_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lane_sz) == 2'b01) |-> lane_ovf[NSEG-1:4] == '0);

    for (genvar i = 0; i < NSEG; i++) begin : g_chk
        assert_wrap_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op) == 2'b00 && !$past(sat_en) && $past(lane_sz) == 2'b00)
            |-> result[i*SEG_W +: SEG_W] ==
                $past(opa[i*SEG_W +: SEG_W] + opb[i*SEG_W +: SEG_W]));

        assert_usat_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op) == 2'b00 && $past(sat_en) && !$past(is_signed)
             && $past(lane_sz) == 2'b00 && lane_ovf[i])
            |-> result[i*SEG_W +: SEG_W] == {SEG_W{1'b1}});

        assert_usat_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op) == 2'b01 && $past(sat_en) && !$past(is_signed)
             && $past(lane_sz) == 2'b00 && lane_ovf[i])
            |-> result[i*SEG_W +: SEG_W] == {SEG_W{1'b0}});

        assert_ssat_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(op[1]) && $past(sat_en) && $past(is_signed)
             && $past(lane_sz) == 2'b00 && lane_ovf[i])
            |-> result[i*SEG_W +: SEG_W] ==
                ($past(opa[(i+1)*SEG_W-1]) ? 8'h80 : 8'h7F));
    end
endmodule

// File: tb/simd_packed_alu_test.sv
module simd_packed_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [1:0]  op = '0, lane_sz = '0;
    logic        sat_en = 1'b0, is_signed = 1'b0;
    logic [63:0] result;
    logic [7:0]  lane_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] prev_res = '0;
    logic [7:0]  prev_ovf = '0;

    always #5 clk = ~clk;

    simd_packed_alu uut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op),
        .lane_sz(lane_sz), .sat_en(sat_en), .is_signed(is_signed),
        .result(result), .lane_ovf(lane_ovf)
    );

    task automatic model(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] o, input logic [1:0] sz,
                         input logic sat, input logic sgn,
                         output logic [63:0] r, output logic [7:0] f);
        int w, nl;
        longint one, mask, ua, ub, sa, sb, s, mx, mn, v;
        logic ov;
        r = '0;
        f = '0;
        one = 1;
        if (o == 2'b10) begin r = a & b; return; end
        if (o == 2'b11) begin r = a | b; return; end
        w = (sz == 2'b01) ? 16 : (sz == 2'b10) ? 32 : 8;
        nl = 64 / w;
        mask = (one << w) - 1;
        for (int k = 0; k < nl; k++) begin
            ua = longint'((a >> (k*w)) & 64'(mask));
            ub = longint'((b >> (k*w)) & 64'(mask));
            if (sgn) begin
                sa = (ua >= (one << (w-1))) ? ua - (one << w) : ua;
                sb = (ub >= (one << (w-1))) ? ub - (one << w) : ub;
                s  = (o == 2'b01) ? sa - sb : sa + sb;
                mx = (one << (w-1)) - 1;
                mn = -(one << (w-1));
                ov = (s > mx) || (s < mn);
                v  = (sat && ov) ? ((s > mx) ? mx : mn) : s;
            end else begin
                s  = (o == 2'b01) ? ua - ub : ua + ub;
                ov = (s > mask) || (s < 0);
                v  = (sat && ov) ? ((s < 0) ? 0 : mask) : s;
            end
            r = r | ((64'(v) & 64'(mask)) << (k*w));
            f[k] = ov;
        end
    endtask

    function automatic string tag_of(input logic [1:0] o, input logic [1:0] sz,
                                     input logic sat, input logic sgn);
        if (o[1])     return "R4";
        if (sz == 2'b11) return "R8";
        if (!sat)     return "R3";
        return sgn ? "R6" : "R5";
    endfunction

    task automatic run(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] o, input logic [1:0] sz,
                       input logic sat, input logic sgn, input string tag);
        logic [63:0] er;
        logic [7:0]  ef;
        model(a, b, o, sz, sat, sgn, er, ef);
        @(negedge clk);
        opa = a; opb = b; op = o; lane_sz = sz; sat_en = sat; is_signed = sgn;
        #1;
        checks++;
        if (result !== prev_res) begin
            errors++;
            $display("FAIL R2: result changed before edge, got %h expected %h", result, prev_res);
        end
        @(negedge clk);
        checks++;
        if (result !== er) begin
            errors++;
            $display("FAIL %s: a=%h b=%h op=%0d sz=%0d sat=%0b sgn=%0b result %h expected %h",
                     tag, a, b, o, sz, sat, sgn, result, er);
        end
        checks++;
        if (lane_ovf !== ef) begin
            errors++;
            $display("FAIL R7: a=%h b=%h op=%0d sz=%0d sgn=%0b flags %h expected %h",
                     a, b, o, sz, sgn, lane_ovf, ef);
        end
        prev_res = er;
        prev_ovf = ef;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [63:0] ra, rb;
        logic [1:0]  ro, rs;
        logic        rsat, rsg;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        opa = 64'hFFFF_FFFF_FFFF_FFFF;
        opb = 64'h0101_0101_0101_0101;
        repeat (3) @(negedge clk);
        checks++;
        if (result !== '0 || lane_ovf !== '0) begin
            errors++;
            $display("FAIL R1: reset state %h/%h expected 0/0", result, lane_ovf);
        end
        rst_n = 1'b1;

        // R3 byte wrap with carry that must not leak
        run(64'h00FF_FF01_80FF_7F00, 64'h0001_0101_8001_0100, 2'b00, 2'b00, 0, 0, "R3");
        // R3 halfword: byte carry must cross inside the lane only
        run(64'hFFFF_00FF_0001_FFFF, 64'h0001_0001_0002_0001, 2'b00, 2'b01, 0, 0, "R3");
        // R3 word wrap and borrow
        run(64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b00, 2'b10, 0, 0, "R3");
        run(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'b01, 2'b10, 0, 0, "R3");
        run(64'h0100_0000_0000_0100, 64'h0001_0001_0001_0001, 2'b01, 2'b00, 0, 0, "R3");
        // R5 unsigned saturation
        run(64'hFF80_F001_00FF_1234, 64'h0180_2001_0001_0000, 2'b00, 2'b00, 1, 0, "R5");
        run(64'h0005_0000_1000_FFFF, 64'h0006_0001_0FFF_0000, 2'b01, 2'b01, 1, 0, "R5");
        // R6 signed saturation to max and min
        run(64'h7F80_7F80_017F_8000, 64'h0101_80FF_0101_0101, 2'b00, 2'b00, 1, 1, "R6");
        run(64'h7F80_0080_7FFF_8000, 64'hFF01_0101_FFFF_0001, 2'b01, 2'b00, 1, 1, "R6");
        run(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 2'b00, 2'b10, 1, 1, "R6");
        // R7 flags in signed wrap mode
        run(64'h7FFF_8000_0001_7FFF, 64'h0001_FFFF_0001_8000, 2'b00, 2'b01, 0, 1, "R7");
        // R4 logic, with arithmetic-style controls that must be ignored
        run(64'hF0F0_1234_FFFF_0000, 64'hFF00_FFFF_0F0F_FFFF, 2'b10, 2'b01, 1, 1, "R4");
        run(64'hF0F0_1234_FFFF_0000, 64'hFF00_FFFF_0F0F_FFFF, 2'b11, 2'b10, 1, 0, "R4");
        // R8 reserved size behaves as bytes
        run(64'h00FF_FF01_80FF_7F00, 64'h0001_0101_8001_0100, 2'b00, 2'b11, 1, 0, "R8");

        for (int n = 0; n < 3000; n++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (n % 4 == 1) ra = ra | 64'hFF00_FF00_FF00_FF00;
            if (n % 4 == 2) rb = rb & 64'h00FF_00FF_00FF_00FF;
            if (n % 8 == 3) ra = 64'h7F7F_7FFF_8080_8000 ^ {56'd0, 8'($urandom)};
            ro   = 2'($urandom);
            rs   = 2'($urandom);
            rsat = 1'($urandom);
            rsg  = 1'($urandom);
            run(ra, rb, ro, rs, rsat, rsg, tag_of(ro, rs, rsat, rsg));
        end

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        checks++;
        if (result !== '0 || lane_ovf !== '0) begin
            errors++;
            $display("FAIL R1: async reset %h/%h expected 0/0", result, lane_ovf);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule